// File: doc/BRIEF.md
# Adaptive Threshold Peak Finder

This block sits behind a pair of correlators in a receiver that locks onto a known training sequence. Once per sample period it gets two signed values. One is the correlation with the expected code (the reference branch). The other is the correlation with a code orthogonal to it, which carries only noise. The squares of the noise-branch values are summed over a sliding window of one reference length. That running sum is the detection threshold, so the threshold follows the noise level as it changes.

When the reference-branch value first rises strictly above the threshold, the block starts a bounded search of two reference lengths. Any later value that is both above the threshold and strictly larger than the best so far becomes the new peak. Each accepted peak emits a one-cycle resync pulse and publishes the peak's sample offset, counted from the first crossing. When the window closes, the block pulses `done`, keeps the final offset and waits for `rearm` before it hunts again.

The control has three states:
- `S_HUNT` waits for a first crossing. Transition `HUNT->SEEK` fires on a valid sample above threshold while the threshold is valid.
- `S_SEEK` tracks the maximum. Transition `SEEK->HOLD` fires on the sample at offset `WIN_LEN`.
- `S_HOLD` ignores samples. Transition `HOLD->HUNT` fires on `rearm`.

Top module: `adaptive_peak_finder`

## Requirements
- R1: After each sample accepted with `smp_valid` high, `thr_level` is the exact sum of `orth_corr*orth_corr` over the last `REF_LEN` accepted samples. Before `REF_LEN` samples have arrived, it is the sum over all samples since reset.
- R2: `thr_ok` goes high once `REF_LEN` samples have been accepted and never falls before reset. While it is low, no search starts and no resync is produced.
- R3: In the hunting state, a sample whose `ref_corr` is strictly greater than the threshold from before that sample starts a search. That sample has offset 0. A sample equal to the threshold starts nothing. The search start gives `resync=1` and `peak_idx=0` one cycle after the sample.
- R4: During a search, a sample above the threshold and strictly greater than the stored maximum replaces the maximum. One cycle later it gives `resync=1` and sets `peak_idx` to that sample's offset from the first crossing.
- R5: During a search, a sample equal to or smaller than the stored maximum changes neither `peak_idx` nor the maximum and gives no resync, so the earliest of equal peaks is kept.
- R6: During a search, a sample larger than the stored maximum but not above the current threshold is not accepted.
- R7: The sample at offset `WIN_LEN` (two reference lengths) is the last one examined. One cycle after it, `done` is high for exactly one cycle and `peak_idx` holds the final peak offset.
- R8: After `done`, samples are ignored: no resync, `peak_idx` unchanged. This lasts until `rearm` is high for a cycle, which returns the block to hunting.
- R9: `rearm` while hunting or searching has no effect.
- R10: A negative `ref_corr` never counts as above the threshold.
- R11: After reset, `thr_level=0`, `thr_ok=0`, `resync=0`, `done=0` and `peak_idx=0`.
- R12: Cycles with `smp_valid` low change neither the threshold nor the search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One cycle per sample period; qualifies both correlation inputs |
| ref_corr | input | CORR_W | Signed reference-branch correlation |
| orth_corr | input | CORR_W | Signed orthogonal-branch correlation |
| rearm | input | 1 | Returns the block from holding to hunting |
| thr_level | output | SUM_W | Current sliding sum of squared orthogonal values |
| thr_ok | output | 1 | Threshold covers a full reference length |
| resync | output | 1 | One-cycle pulse per accepted peak |
| done | output | 1 | One-cycle pulse at window close |
| peak_idx | output | OFF_W | Offset of the best peak from the first crossing |

## Verification
The bench first feeds strong reference values while the threshold is still filling, which separates a correct start-up blanking from early triggering. Directed samples follow: values exactly at the threshold, equal to the stored maximum, negative, and larger-than-maximum but under a freshly raised threshold. These distinguish the strict comparisons and the tie rule from looser variants. A long random run then mixes low-level noise, occasional strong peaks, idle gaps and `rearm` pulses in every state. This exercises window length, holding and sliding-sum exactness, with every output compared to a bench model after each sample.

// File: rtl/apf_pkg.sv
package apf_pkg;
    typedef enum logic [1:0] {
        S_HUNT = 2'd0,
        S_SEEK = 2'd1,
        S_HOLD = 2'd2
    } srch_state_t;
endpackage

// File: rtl/noise_floor_sum.sv
module noise_floor_sum #(
    parameter int CORR_W  = 12,
    parameter int REF_LEN = 60,
    parameter int SUM_W   = 2 * CORR_W + $clog2(REF_LEN) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic signed [CORR_W-1:0] orth_corr,
    output logic [SUM_W-1:0]         thr_level,
    output logic                     thr_ok
);
    localparam int SQ_W   = 2 * CORR_W;
    localparam int FILL_W = $clog2(REF_LEN + 1);

    logic signed [SQ_W-1:0] sq_s;
    logic [SQ_W-1:0]        sq_new;
    logic [SQ_W-1:0]        dly [REF_LEN];
    logic [SUM_W-1:0]       sum_q;
    logic [FILL_W-1:0]      fill_q;

    // single multiplier: the square is never negative
    assign sq_s   = orth_corr * orth_corr;
    assign sq_new = sq_s;

    // delay line of squares, one stage per sample of the reference length
    always_ff @(posedge clk) begin
        if (!rst_n)
            dly[0] <= '0;
        else if (smp_valid)
            dly[0] <= sq_new;
    end

    for (genvar g = 1; g < REF_LEN; g++) begin : g_dly
        always_ff @(posedge clk) begin
            if (!rst_n)
                dly[g] <= '0;
            else if (smp_valid)
                dly[g] <= dly[g-1];
        end
    end

    // add the newest square, drop the one leaving the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q  <= '0;
            fill_q <= '0;
        end else if (smp_valid) begin
            sum_q <= sum_q + SUM_W'(sq_new) - SUM_W'(dly[REF_LEN-1]);
            if (fill_q != FILL_W'(REF_LEN))
                fill_q <= fill_q + 1'b1;
        end
    end

    assign thr_level = sum_q;
    assign thr_ok    = (fill_q == FILL_W'(REF_LEN));

    // R2
    thr_ok_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(thr_ok));

    // R12
    thr_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(thr_level));
endmodule

// File: rtl/peak_window_fsm.sv
module peak_window_fsm
    import apf_pkg::*;
#(
    parameter int CORR_W  = 12,
    parameter int SUM_W   = 30,
    parameter int WIN_LEN = 120,
    parameter int OFF_W   = $clog2(WIN_LEN + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic signed [CORR_W-1:0] ref_corr,
    input  logic [SUM_W-1:0]         thr_level,
    input  logic                     thr_ok,
    input  logic                     rearm,
    output logic                     resync,
    output logic                     done,
    output logic [OFF_W-1:0]         peak_idx
);
    srch_state_t state_q, state_nx;

    logic [OFF_W-1:0]         off_q;
    logic [OFF_W-1:0]         off_inc;
    logic signed [CORR_W-1:0] max_q;
    logic [OFF_W-1:0]         idx_q;
    logic                     resync_q;
    logic                     done_q;
    logic [SUM_W-1:0]         ref_ext;
    logic                     above;
    logic                     last_smp;

    // only a non-negative value can clear the threshold
    assign ref_ext  = {{(SUM_W-CORR_W){1'b0}}, ref_corr};
    assign above    = thr_ok && !ref_corr[CORR_W-1] && (ref_ext > thr_level);
    assign off_inc  = off_q + 1'b1;
    assign last_smp = (off_inc == OFF_W'(WIN_LEN));

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_HUNT: if (smp_valid && above)    state_nx = S_SEEK;
            S_SEEK: if (smp_valid && last_smp) state_nx = S_HOLD;
            S_HOLD: if (rearm)                 state_nx = S_HUNT;
            default:                           state_nx = S_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_HUNT;
        else
            state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q    <= '0;
            max_q    <= '0;
            idx_q    <= '0;
            resync_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            resync_q <= 1'b0;
            done_q   <= 1'b0;
            unique case (state_q)
                S_HUNT: begin
                    if (smp_valid && above) begin
                        off_q    <= '0;
                        max_q    <= ref_corr;
                        idx_q    <= '0;
                        resync_q <= 1'b1;
                    end
                end
                S_SEEK: begin
                    if (smp_valid) begin
                        off_q <= off_inc;
                        if (above && (ref_corr > max_q)) begin
                            max_q    <= ref_corr;
                            idx_q    <= off_inc;
                            resync_q <= 1'b1;
                        end
                        if (last_smp)
                            done_q <= 1'b1;
                    end
                end
                S_HOLD: ;
                default: ;
            endcase
        end
    end

    assign resync   = resync_q;
    assign done     = done_q;
    assign peak_idx = idx_q;

    // R2
    resync_needs_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resync |-> thr_ok);

    // R4
    resync_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resync |-> $past(smp_valid));

    // R5
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !resync |-> $stable(peak_idx));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    idx_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (peak_idx <= OFF_W'(WIN_LEN)));

    // R8
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD) |=> !resync);
endmodule

// File: rtl/adaptive_peak_finder.sv
module adaptive_peak_finder #(
    parameter int CORR_W  = 12,
    parameter int REF_LEN = 60,
    parameter int WIN_LEN = 2 * REF_LEN,
    parameter int SUM_W   = 2 * CORR_W + $clog2(REF_LEN) + 1,
    parameter int OFF_W   = $clog2(WIN_LEN + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic signed [CORR_W-1:0] ref_corr,
    input  logic signed [CORR_W-1:0] orth_corr,
    input  logic                     rearm,
    output logic [SUM_W-1:0]         thr_level,
    output logic                     thr_ok,
    output logic                     resync,
    output logic                     done,
    output logic [OFF_W-1:0]         peak_idx
);
    noise_floor_sum #(
        .CORR_W (CORR_W),
        .REF_LEN(REF_LEN),
        .SUM_W  (SUM_W)
    ) u_thr (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .orth_corr(orth_corr),
        .thr_level(thr_level),
        .thr_ok   (thr_ok)
    );

    peak_window_fsm #(
        .CORR_W (CORR_W),
        .SUM_W  (SUM_W),
        .WIN_LEN(WIN_LEN),
        .OFF_W  (OFF_W)
    ) u_srch (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .ref_corr (ref_corr),
        .thr_level(thr_level),
        .thr_ok   (thr_ok),
        .rearm    (rearm),
        .resync   (resync),
        .done     (done),
        .peak_idx (peak_idx)
    );
endmodule

// File: tb/sim_adaptive_peak_finder.sv
module sim_adaptive_peak_finder;
    localparam int CORR_W  = 12;
    localparam int REF_LEN = 60;
    localparam int WIN_LEN = 2 * REF_LEN;
    localparam int SUM_W   = 2 * CORR_W + $clog2(REF_LEN) + 1;
    localparam int OFF_W   = $clog2(WIN_LEN + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic signed [CORR_W-1:0] ref_corr = '0;
    logic signed [CORR_W-1:0] orth_corr = '0;
    logic rearm = 1'b0;
    logic [SUM_W-1:0] thr_level;
    logic thr_ok, resync, done;
    logic [OFF_W-1:0] peak_idx;

    always #2.5 clk = ~clk;

    adaptive_peak_finder #(
        .CORR_W(CORR_W), .REF_LEN(REF_LEN), .WIN_LEN(WIN_LEN),
        .SUM_W(SUM_W), .OFF_W(OFF_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .ref_corr(ref_corr), .orth_corr(orth_corr), .rearm(rearm),
        .thr_level(thr_level), .thr_ok(thr_ok), .resync(resync),
        .done(done), .peak_idx(peak_idx)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state: 0 hunt, 1 seek, 2 hold
    longint hist [REF_LEN];
    int     hptr = 0;
    longint m_sum = 0;
    int     m_fill = 0;
    int     m_state = 0;
    int     m_off = 0;
    int     m_max = 0;
    int     m_idx = 0;
    bit     e_resync = 0;
    bit     e_done = 0;

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic void model_step(input int r, input int o);
        bit ok = (m_fill >= REF_LEN);
        bit above = ok && (longint'(r) > m_sum);
        e_resync = 0;
        e_done = 0;
        if (m_state == 0) begin
            if (above) begin
                m_state = 1; m_off = 0; m_max = r; m_idx = 0; e_resync = 1;
            end
        end else if (m_state == 1) begin
            m_off++;
            if (above && r > m_max) begin
                m_max = r; m_idx = m_off; e_resync = 1;
            end
            if (m_off == WIN_LEN) begin
                e_done = 1; m_state = 2;
            end
        end
        m_sum = m_sum + longint'(o) * o - hist[hptr];
        hist[hptr] = longint'(o) * o;
        hptr = (hptr + 1) % REF_LEN;
        if (m_fill < REF_LEN) m_fill++;
    endfunction

    task automatic check_all(input string tag);
        check({tag, " R1 thr_level"}, thr_level, m_sum);
        check({tag, " R2 thr_ok"}, thr_ok, (m_fill >= REF_LEN));
        check({tag, " R3/R4 resync"}, resync, e_resync);
        check({tag, " R7 done"}, done, e_done);
        check({tag, " R5 peak_idx"}, peak_idx, m_idx);
    endtask

    task automatic send(input int r, input int o, input string tag);
        @(negedge clk);
        smp_valid = 1'b1;
        ref_corr = CORR_W'(r);
        orth_corr = CORR_W'(o);
        model_step(r, o);
        @(negedge clk);
        smp_valid = 1'b0;
        check_all(tag);
    endtask

    task automatic pulse_rearm(input string tag);
        @(negedge clk);
        rearm = 1'b1;
        if (m_state == 2) m_state = 0;
        @(negedge clk);
        rearm = 1'b0;
        e_resync = 0;
        e_done = 0;
        check_all(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_corr = CORR_W'($urandom_range(0, 2047));
            orth_corr = CORR_W'($urandom_range(0, 2047));
        end
        e_resync = 0;
        e_done = 0;
        check_all("R12 idle");
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int keep_idx;
        void'($urandom(32'd20240611));
        for (int i = 0; i < REF_LEN; i++) hist[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R11 reset");

        // R2: strong refs while the threshold fills must not trigger
        for (int i = 0; i < REF_LEN; i++)
            send(2000, int'($urandom_range(0, 6)) - 3, "R2 fill");
        idle(3);

        // R10: negative never triggers
        send(-2000, 2, "R10 negative");
        // R3: equal to threshold starts nothing
        send(int'(m_sum), 1, "R3 equal");
        // R3: just above starts search at offset 0
        send(int'(m_sum) + 1, 1, "R3 start");
        check("R3 start resync", resync, 1);
        check("R3 start idx", peak_idx, 0);
        // R5: tie keeps the earlier peak
        send(m_max, 1, "R5 tie");
        check("R5 tie no resync", resync, 0);
        // R4: larger peak at offset 2
        send(m_max + 50, 1, "R4 larger");
        check("R4 idx", peak_idx, 2);
        // R9: rearm while searching ignored
        pulse_rearm("R9 rearm seek");
        // R6: raise the threshold, then a larger value under it
        for (int i = 0; i < 3; i++) send(0, 40, "R6 raise");
        send(m_max + 10, 0, "R6 under thr");
        check("R6 no accept", resync, 0);
        keep_idx = m_idx;
        // fill the rest of the window
        while (m_state == 1) send(5, 0, "R7 window");
        check("R7 done at close", done, 1);
        check("R7 final idx", peak_idx, keep_idx);
        // R8: samples ignored while holding
        for (int i = 0; i < 5; i++) send(2047, 0, "R8 hold");
        check("R8 still idx", peak_idx, keep_idx);
        pulse_rearm("R8 rearm");
        for (int i = 0; i < REF_LEN; i++) send(0, 1, "R1 settle");
        send(int'(m_sum) + 3, 1, "R8 retrigger");
        check("R8 retrigger resync", resync, 1);
        pulse_rearm("R9 rearm hunt");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int o = int'($urandom_range(0, 6)) - 3;
            int r;
            int pick = int'($urandom_range(0, 99));
            if (pick < 75) r = int'($urandom_range(0, 700)) - 350;
            else r = int'($urandom_range(0, 4095)) - 2048;
            send(r, o, "rnd");
            if ($urandom_range(0, 19) == 0) idle(int'($urandom_range(1, 3)));
            if ($urandom_range(0, 39) == 0 || (m_state == 2 && $urandom_range(0, 3) == 0))
                pulse_rearm("R8/R9 rnd rearm");
        end

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule